// File: doc/BRIEF.md
# Multi-Channel Queue Register Bank

This block is the software-visible control plane of a multi-channel descriptor DMA engine. Each channel has its own 256-byte register window, and all windows hang off one 32-bit register bus. A window holds that channel's submission and completion ring base addresses, the ring sizes (stored as entry count minus one), the submission tail pointer, the completion head pointer, enable and pause controls, and a self-clearing queue reset. It also holds a read-only engine state field and a 13-source interrupt status vector with a mask.

The channel engines take their ring setup from the block's outputs. The engines report their state and raise interrupt events through per-channel inputs. Software rings a channel's doorbell by writing the new tail. The block then drives a one-cycle pulse alongside the updated tail value. A single global register picks endpoint or root-complex operation.

Top module: `qp_regbank`

## Requirements
- R1: Channel c's registers sit at byte address c*0x100 + offset. The offsets are: submission base low 0x00, submission base high 0x04, submission depth 0x08, completion base low 0x10, completion base high 0x14, completion depth 0x18 and completion head 0x1C. Base registers keep all 32 bits. Depth and pointer registers keep the low 16 bits, and their upper bits read 0. Each value is also driven on the matching channel output.
- R2: The control word at offset 0x20 holds enable in bit 0 and pause in bit 4. These bits drive ch_enable_o and ch_pause_o. Every other bit of the word reads 0.
- R3: Writing 1 to bit 0 at offset 0x24 clears that channel's submission tail and completion head on the write's clock edge. The same write drives ch_reset_o high for exactly the following cycle. Offset 0x24 always reads 0.
- R4: Offset 0x30 returns that channel's 4-bit ch_state_i field in bits 3:0 and 0 above.
- R5: The interrupt status at offset 0x40, bits 12:0, latches each high irq_src_i bit and holds it until cleared. Writing a 1 to a bit clears it, and writing a 0 leaves it alone. When a set and a clear of the same bit meet in one cycle, the set wins.
- R6: The interrupt mask at offset 0x44 resets to 0x1FFF. A mask bit of 1 blocks the matching status bit. irq_o of a channel is the OR of its status bits whose mask bit is 0.
- R7: A write to the submission tail at offset 0x0C stores the low 16 bits. The new value appears on sq_tail_o, and db_pulse_o of that channel is high for exactly the cycle after the write. The tail reads back.
- R8: The global mode register at byte address 0x217C holds bit 0 (0 = endpoint, 1 = root complex). It drives mode_rc_o and reads back.
- R9: Reads from offsets not listed, and from windows of channels at or above NUM_CH, return 0. Writes to them change no register.
- R10: Read data appears on rdata in the cycle after rd_en and holds until the next read. After reset every register is 0 except the interrupt mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 14 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| ch_state_i | input | NUM_CH*4 | Engine state per channel |
| irq_src_i | input | NUM_CH*13 | Interrupt event pulses per channel |
| ch_enable_o | output | NUM_CH | Queue enable per channel |
| ch_pause_o | output | NUM_CH | Queue pause per channel |
| ch_reset_o | output | NUM_CH | One-cycle queue reset per channel |
| db_pulse_o | output | NUM_CH | One-cycle doorbell per channel |
| sq_tail_o | output | NUM_CH*16 | Submission tail per channel |
| cq_head_o | output | NUM_CH*16 | Completion head per channel |
| sq_base_o | output | NUM_CH*64 | Submission ring base per channel |
| cq_base_o | output | NUM_CH*64 | Completion ring base per channel |
| sq_depth_o | output | NUM_CH*16 | Submission ring size minus one |
| cq_depth_o | output | NUM_CH*16 | Completion ring size minus one |
| irq_o | output | NUM_CH | Unmasked interrupt per channel |
| mode_rc_o | output | 1 | Root-complex mode select |

## Verification
A stuck or wrongly decoded register shows on the channel outputs and on rdata one cycle after the write that should have changed it. A doorbell or reset flop that fails to self-clear keeps db_pulse_o or ch_reset_o high a second cycle, and that second cycle is checked directly. Status latching errors appear on irq_o as soon as the mask is opened, or on the next read of offset 0x40. Aliasing between windows is caught by reading neighbouring channels after each write.

// File: rtl/qp_regbank_pkg.sv
package qp_regbank_pkg;
  localparam int WIN_LOG2 = 8;
  localparam logic [7:0] OFF_SQ_BL   = 8'h00;
  localparam logic [7:0] OFF_SQ_BH   = 8'h04;
  localparam logic [7:0] OFF_SQ_DEP  = 8'h08;
  localparam logic [7:0] OFF_SQ_TAIL = 8'h0C;
  localparam logic [7:0] OFF_CQ_BL   = 8'h10;
  localparam logic [7:0] OFF_CQ_BH   = 8'h14;
  localparam logic [7:0] OFF_CQ_DEP  = 8'h18;
  localparam logic [7:0] OFF_CQ_HEAD = 8'h1C;
  localparam logic [7:0] OFF_CTRL    = 8'h20;
  localparam logic [7:0] OFF_QRST    = 8'h24;
  localparam logic [7:0] OFF_STATE   = 8'h30;
  localparam logic [7:0] OFF_ISTS    = 8'h40;
  localparam logic [7:0] OFF_IMSK    = 8'h44;
  localparam int EN_BIT    = 0;
  localparam int PAUSE_BIT = 4;
  localparam int MODE_ADDR = 'h217C;
endpackage

// File: rtl/qp_chan_regs.sv
module qp_chan_regs
  import qp_regbank_pkg::*;
#(
  parameter int DW      = 32,
  parameter int PTR_W   = 16,
  parameter int STAT_W  = 13,
  parameter int STATE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_sel,
  input  logic [7:0]          off_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [STATE_W-1:0]  state_i,
  input  logic [STAT_W-1:0]   irq_src_i,
  output logic [DW-1:0]       rd_word_o,
  output logic                enable_o,
  output logic                pause_o,
  output logic                reset_o,
  output logic                db_o,
  output logic [PTR_W-1:0]    sq_tail_o,
  output logic [PTR_W-1:0]    cq_head_o,
  output logic [2*DW-1:0]     sq_base_o,
  output logic [2*DW-1:0]     cq_base_o,
  output logic [PTR_W-1:0]    sq_depth_o,
  output logic [PTR_W-1:0]    cq_depth_o,
  output logic                irq_o
);
  logic [DW-1:0]     sq_bl_q, sq_bh_q, cq_bl_q, cq_bh_q;
  logic [DW-1:0]     sq_bl_d, sq_bh_d, cq_bl_d, cq_bh_d;
  logic [PTR_W-1:0]  sq_dep_q, cq_dep_q, sq_tail_q, cq_head_q;
  logic [PTR_W-1:0]  sq_dep_d, cq_dep_d, sq_tail_d, cq_head_d;
  logic              en_q, en_d, pause_q, pause_d, rst_q, rst_d, db_q, db_d;
  logic [STAT_W-1:0] ists_q, ists_d, imsk_q, imsk_d, clr_bits;

  always_comb begin
    sq_bl_d = sq_bl_q; sq_bh_d = sq_bh_q; cq_bl_d = cq_bl_q; cq_bh_d = cq_bh_q;
    sq_dep_d = sq_dep_q; cq_dep_d = cq_dep_q;
    sq_tail_d = sq_tail_q; cq_head_d = cq_head_q;
    en_d = en_q; pause_d = pause_q; imsk_d = imsk_q;
    clr_bits = '0;
    rst_d = 1'b0;
    db_d  = 1'b0;
    if (wr_sel) begin
      case (off_i)
        OFF_SQ_BL:   sq_bl_d = wdata_i;
        OFF_SQ_BH:   sq_bh_d = wdata_i;
        OFF_CQ_BL:   cq_bl_d = wdata_i;
        OFF_CQ_BH:   cq_bh_d = wdata_i;
        OFF_SQ_DEP:  sq_dep_d = wdata_i[PTR_W-1:0];
        OFF_CQ_DEP:  cq_dep_d = wdata_i[PTR_W-1:0];
        OFF_SQ_TAIL: begin sq_tail_d = wdata_i[PTR_W-1:0]; db_d = 1'b1; end
        OFF_CQ_HEAD: cq_head_d = wdata_i[PTR_W-1:0];
        OFF_CTRL:    begin en_d = wdata_i[EN_BIT]; pause_d = wdata_i[PAUSE_BIT]; end
        OFF_QRST:    rst_d = wdata_i[0];
        OFF_ISTS:    clr_bits = wdata_i[STAT_W-1:0];
        OFF_IMSK:    imsk_d = wdata_i[STAT_W-1:0];
        default:     ;
      endcase
    end
    if (rst_d) begin
      sq_tail_d = '0;
      cq_head_d = '0;
    end
    ists_d = (ists_q & ~clr_bits) | irq_src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_bl_q <= '0; sq_bh_q <= '0; cq_bl_q <= '0; cq_bh_q <= '0;
      sq_dep_q <= '0; cq_dep_q <= '0; sq_tail_q <= '0; cq_head_q <= '0;
      en_q <= 1'b0; pause_q <= 1'b0; rst_q <= 1'b0; db_q <= 1'b0;
      ists_q <= '0; imsk_q <= '1;
    end else begin
      sq_bl_q <= sq_bl_d; sq_bh_q <= sq_bh_d; cq_bl_q <= cq_bl_d; cq_bh_q <= cq_bh_d;
      sq_dep_q <= sq_dep_d; cq_dep_q <= cq_dep_d;
      sq_tail_q <= sq_tail_d; cq_head_q <= cq_head_d;
      en_q <= en_d; pause_q <= pause_d; rst_q <= rst_d; db_q <= db_d;
      ists_q <= ists_d; imsk_q <= imsk_d;
    end
  end

  always_comb begin
    rd_word_o = '0;
    case (off_i)
      OFF_SQ_BL:   rd_word_o = sq_bl_q;
      OFF_SQ_BH:   rd_word_o = sq_bh_q;
      OFF_CQ_BL:   rd_word_o = cq_bl_q;
      OFF_CQ_BH:   rd_word_o = cq_bh_q;
      OFF_SQ_DEP:  rd_word_o[PTR_W-1:0] = sq_dep_q;
      OFF_CQ_DEP:  rd_word_o[PTR_W-1:0] = cq_dep_q;
      OFF_SQ_TAIL: rd_word_o[PTR_W-1:0] = sq_tail_q;
      OFF_CQ_HEAD: rd_word_o[PTR_W-1:0] = cq_head_q;
      OFF_CTRL:    begin rd_word_o[EN_BIT] = en_q; rd_word_o[PAUSE_BIT] = pause_q; end
      OFF_STATE:   rd_word_o[STATE_W-1:0] = state_i;
      OFF_ISTS:    rd_word_o[STAT_W-1:0] = ists_q;
      OFF_IMSK:    rd_word_o[STAT_W-1:0] = imsk_q;
      default:     ;
    endcase
  end

  assign enable_o   = en_q;
  assign pause_o    = pause_q;
  assign reset_o    = rst_q;
  assign db_o       = db_q;
  assign sq_tail_o  = sq_tail_q;
  assign cq_head_o  = cq_head_q;
  assign sq_base_o  = {sq_bh_q, sq_bl_q};
  assign cq_base_o  = {cq_bh_q, cq_bl_q};
  assign sq_depth_o = sq_dep_q;
  assign cq_depth_o = cq_dep_q;
  assign irq_o      = |(ists_q & ~imsk_q);

  // R7: a doorbell pulse follows only a tail write
  p_doorbell_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    db_q |-> $past(wr_sel && off_i == OFF_SQ_TAIL));
  // R3: reset pulse follows only a reset write
  p_reset_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> $past(wr_sel && off_i == OFF_QRST && wdata_i[0]));
  // R3: pointers are zero while the reset pulse is out
  p_reset_ptrs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (sq_tail_q == '0 && cq_head_q == '0));
  // R5: written ones clear unless set again in the same cycle
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_sel && off_i == OFF_ISTS) |->
      ((ists_q & $past(wdata_i[STAT_W-1:0]) & ~$past(irq_src_i)) == '0));
  // R6: a fully masked channel never interrupts
  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&imsk_q) |-> !irq_o);
endmodule

// File: rtl/qp_read_mux.sv
module qp_read_mux
  import qp_regbank_pkg::*;
#(
  parameter int NUM_CH = 30,
  parameter int ADDR_W = 14,
  parameter int DW     = 32
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        mode_i,
  input  logic [NUM_CH-1:0][DW-1:0]   ch_rd_i,
  output logic [DW-1:0]               rd_o
);
  localparam int CH_W = ADDR_W - WIN_LOG2;
  logic [CH_W-1:0] ch_idx;
  assign ch_idx = addr_i[ADDR_W-1:WIN_LOG2];

  always_comb begin
    rd_o = '0;
    if (addr_i == ADDR_W'(MODE_ADDR)) begin
      rd_o[0] = mode_i;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == CH_W'(c)) rd_o = ch_rd_i[c];
      end
    end
  end
endmodule

// File: rtl/qp_regbank.sv
module qp_regbank
  import qp_regbank_pkg::*;
#(
  parameter int NUM_CH  = 30,
  parameter int ADDR_W  = 14,
  parameter int DW      = 32,
  parameter int PTR_W   = 16,
  parameter int STAT_W  = 13,
  parameter int STATE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  input  logic [NUM_CH*STATE_W-1:0] ch_state_i,
  input  logic [NUM_CH*STAT_W-1:0]  irq_src_i,
  output logic [NUM_CH-1:0]         ch_enable_o,
  output logic [NUM_CH-1:0]         ch_pause_o,
  output logic [NUM_CH-1:0]         ch_reset_o,
  output logic [NUM_CH-1:0]         db_pulse_o,
  output logic [NUM_CH*PTR_W-1:0]   sq_tail_o,
  output logic [NUM_CH*PTR_W-1:0]   cq_head_o,
  output logic [NUM_CH*2*DW-1:0]    sq_base_o,
  output logic [NUM_CH*2*DW-1:0]    cq_base_o,
  output logic [NUM_CH*PTR_W-1:0]   sq_depth_o,
  output logic [NUM_CH*PTR_W-1:0]   cq_depth_o,
  output logic [NUM_CH-1:0]         irq_o,
  output logic                      mode_rc_o
);
  localparam int CH_W = ADDR_W - WIN_LOG2;

  logic [NUM_CH-1:0][DW-1:0] ch_rd;
  logic [DW-1:0]             rd_word, rdata_d, rdata_q;
  logic                      mode_d, mode_q, mode_hit;
  logic [CH_W-1:0]           ch_idx;

  assign ch_idx   = addr[ADDR_W-1:WIN_LOG2];
  assign mode_hit = (addr == ADDR_W'(MODE_ADDR));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qp_chan_regs #(.DW(DW), .PTR_W(PTR_W), .STAT_W(STAT_W), .STATE_W(STATE_W)) i_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sel     (wr_en && (ch_idx == CH_W'(c))),
      .off_i      (addr[WIN_LOG2-1:0]),
      .wdata_i    (wdata),
      .state_i    (ch_state_i[c*STATE_W +: STATE_W]),
      .irq_src_i  (irq_src_i[c*STAT_W +: STAT_W]),
      .rd_word_o  (ch_rd[c]),
      .enable_o   (ch_enable_o[c]),
      .pause_o    (ch_pause_o[c]),
      .reset_o    (ch_reset_o[c]),
      .db_o       (db_pulse_o[c]),
      .sq_tail_o  (sq_tail_o[c*PTR_W +: PTR_W]),
      .cq_head_o  (cq_head_o[c*PTR_W +: PTR_W]),
      .sq_base_o  (sq_base_o[c*2*DW +: 2*DW]),
      .cq_base_o  (cq_base_o[c*2*DW +: 2*DW]),
      .sq_depth_o (sq_depth_o[c*PTR_W +: PTR_W]),
      .cq_depth_o (cq_depth_o[c*PTR_W +: PTR_W]),
      .irq_o      (irq_o[c])
    );
  end

  qp_read_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DW(DW)) i_rmux (
    .addr_i  (addr),
    .mode_i  (mode_q),
    .ch_rd_i (ch_rd),
    .rd_o    (rd_word)
  );

  always_comb begin
    mode_d  = (wr_en && mode_hit) ? wdata[0] : mode_q;
    rdata_d = rd_en ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign mode_rc_o = mode_q;

  // R10: read data holds between reads
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));
  // R8: mode follows a write to its address
  p_mode_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && mode_hit) |-> (mode_rc_o == $past(wdata[0])));
endmodule

// File: tb/test_qp_regbank.sv
module test_qp_regbank;
  localparam int NCH = 30;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH*4-1:0]  ch_state_i = '0;
  logic [NCH*13-1:0] irq_src_i = '0;
  logic [NCH-1:0] ch_enable_o, ch_pause_o, ch_reset_o, db_pulse_o, irq_o;
  logic [NCH*16-1:0] sq_tail_o, cq_head_o, sq_depth_o, cq_depth_o;
  logic [NCH*64-1:0] sq_base_o, cq_base_o;
  logic mode_rc_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  qp_regbank i_qp_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_state_i(ch_state_i), .irq_src_i(irq_src_i),
    .ch_enable_o(ch_enable_o), .ch_pause_o(ch_pause_o), .ch_reset_o(ch_reset_o),
    .db_pulse_o(db_pulse_o), .sq_tail_o(sq_tail_o), .cq_head_o(cq_head_o),
    .sq_base_o(sq_base_o), .cq_base_o(cq_base_o), .sq_depth_o(sq_depth_o),
    .cq_depth_o(cq_depth_o), .irq_o(irq_o), .mode_rc_o(mode_rc_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 14'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 14'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic int ra(input int ch, input int off);
    return ch * 256 + off;
  endfunction

  task automatic t_reset_state;
    logic [31:0] d;
    chk("R10 reset enables", 64'(ch_enable_o), 64'(0));
    chk("R10 reset irq", 64'(irq_o), 64'(0));
    rd(ra(0, 'h44), d); chk("R6 mask reset value", 64'(d), 64'h1FFF);
    rd(ra(7, 'h00), d); chk("R10 base reset", 64'(d), 64'(0));
  endtask

  task automatic t_window_rw;
    logic [31:0] d;
    wr(ra(0, 'h00), 32'hDEAD_BEEF);
    wr(ra(0, 'h04), 32'h1234_5678);
    wr(ra(29, 'h10), 32'hCAFE_0001);
    wr(ra(29, 'h18), 32'hFFFF_03FF);
    wr(ra(0, 'h08), 32'h0000_03FF);
    chk("R1 sq base out ch0", sq_base_o[0 +: 64], 64'h1234_5678_DEAD_BEEF);
    chk("R1 cq base out ch29", cq_base_o[29*64 +: 64], 64'h0000_0000_CAFE_0001);
    chk("R1 cq depth out ch29", 64'(cq_depth_o[29*16 +: 16]), 64'h03FF);
    chk("R1 sq depth out ch0", 64'(sq_depth_o[0 +: 16]), 64'h03FF);
    rd(ra(29, 'h18), d); chk("R1 depth readback truncated", 64'(d), 64'h03FF);
    rd(ra(0, 'h04), d); chk("R1 base high readback", 64'(d), 64'h1234_5678);
    rd(ra(1, 'h00), d); chk("R1 no alias into ch1", 64'(d), 64'(0));
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(ra(2, 'h20), 32'hFFFF_FFFF);
    chk("R2 enable ch2", 64'(ch_enable_o), 64'(1 << 2));
    chk("R2 pause ch2", 64'(ch_pause_o), 64'(1 << 2));
    rd(ra(2, 'h20), d); chk("R2 ctrl readback", 64'(d), 64'h11);
    wr(ra(2, 'h20), 32'h0000_0001);
    chk("R2 pause cleared", 64'(ch_pause_o), 64'(0));
    chk("R2 enable kept", 64'(ch_enable_o), 64'(1 << 2));
  endtask

  task automatic t_doorbell;
    logic [31:0] d;
    wr(ra(5, 'h0C), 32'h0001_0007);
    chk("R7 doorbell pulse", 64'(db_pulse_o), 64'(1 << 5));
    chk("R7 tail value", 64'(sq_tail_o[5*16 +: 16]), 64'h7);
    @(negedge clk);
    chk("R7 doorbell one cycle", 64'(db_pulse_o), 64'(0));
    rd(ra(5, 'h0C), d); chk("R7 tail readback", 64'(d), 64'h7);
    wr(ra(5, 'h1C), 32'h9);
    chk("R7 head write no doorbell", 64'(db_pulse_o), 64'(0));
    chk("R1 head out", 64'(cq_head_o[5*16 +: 16]), 64'h9);
  endtask

  task automatic t_queue_reset;
    logic [31:0] d;
    wr(ra(5, 'h24), 32'h1);
    chk("R3 reset pulse", 64'(ch_reset_o), 64'(1 << 5));
    chk("R3 tail cleared", 64'(sq_tail_o[5*16 +: 16]), 64'h0);
    chk("R3 head cleared", 64'(cq_head_o[5*16 +: 16]), 64'h0);
    @(negedge clk);
    chk("R3 reset self clears", 64'(ch_reset_o), 64'(0));
    rd(ra(5, 'h24), d); chk("R3 reset reads zero", 64'(d), 64'(0));
    wr(ra(5, 'h24), 32'h0);
    chk("R3 zero write no pulse", 64'(ch_reset_o), 64'(0));
  endtask

  task automatic t_state;
    logic [31:0] d;
    ch_state_i[11*4 +: 4] = 4'hA;
    rd(ra(11, 'h30), d); chk("R4 state ch11", 64'(d), 64'hA);
    rd(ra(10, 'h30), d); chk("R4 state ch10", 64'(d), 64'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    @(negedge clk); irq_src_i[3*13 + 5] = 1'b1;
    @(negedge clk); irq_src_i = '0;
    chk("R6 masked no irq", 64'(irq_o), 64'(0));
    rd(ra(3, 'h40), d); chk("R5 status latched", 64'(d), 64'h20);
    wr(ra(3, 'h44), 32'h0);
    chk("R6 unmasked irq", 64'(irq_o), 64'(1 << 3));
    wr(ra(3, 'h40), 32'h0000_0010);
    chk("R5 zero write keeps", 64'(irq_o), 64'(1 << 3));
    wr(ra(3, 'h40), 32'h0000_0020);
    chk("R5 w1c clears irq", 64'(irq_o), 64'(0));
    @(negedge clk);
    wr_en = 1'b1; addr = 14'(ra(3, 'h40)); wdata = 32'h4;
    irq_src_i[3*13 + 2] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; irq_src_i = '0;
    rd(ra(3, 'h40), d); chk("R5 set wins over clear", 64'(d), 64'h4);
    wr(ra(3, 'h44), 32'h0000_0004);
    chk("R6 mask blocks bit2", 64'(irq_o), 64'(0));
  endtask

  task automatic t_mode;
    logic [31:0] d;
    wr('h217C, 32'h1);
    chk("R8 mode rc", 64'(mode_rc_o), 64'(1));
    rd('h217C, d); chk("R8 mode readback", 64'(d), 64'h1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(ra(30, 'h00), 32'hFFFF_FFFF);
    wr(ra(0, 'h2C), 32'hFFFF_FFFF);
    chk("R9 ch0 base untouched", sq_base_o[0 +: 64], 64'h1234_5678_DEAD_BEEF);
    chk("R9 no enable change", 64'(ch_enable_o), 64'(1 << 2));
    rd(ra(30, 'h00), d); chk("R9 out of range reads zero", 64'(d), 64'(0));
    rd(ra(0, 'h2C), d); chk("R9 hole reads zero", 64'(d), 64'(0));
    rd(ra(11, 'h30), d);
    ch_state_i[11*4 +: 4] = 4'h3;
    @(negedge clk); @(negedge clk);
    chk("R10 rdata holds without read", 64'(rdata), 64'hA);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state;
    t_window_rw;
    t_ctrl;
    t_doorbell;
    t_queue_reset;
    t_state;
    t_irq;
    t_mode;
    t_unmapped;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule